// File: doc/BRIEF.md
# Per-Core Reset Control Register Block

This block holds the reset controls for four processor cores together with two companion subsystem reset words, all reached over a simple 32-bit register bus. Each core owns one bit of the core reset word. The bit drives a level hold output for that core. When a write clears a bit that was set, the block also produces a one-cycle release pulse, which starts that core's restart sequence.

Core actions come only from bit transitions seen at write time. The stored level alone never triggers them. Rewriting the value already held therefore does nothing. Block reset loads the core word with all core bits set and produces no release pulse. The two companion words are plain stored registers. Every word clears its reserved bits on write and reads them back as zero.

Top module: `core_rst_ctrl`

## Requirements
- R1: After reset the words read as follows: word address 0 (core reset word) reads 0x00003D0F, word address 1 (top reset word) reads 0x000F9FFE, and word address 2 (memory subsystem word) reads 0x0000000C. The last value is 0xF with that word's reserved bits cleared.
- R2: A write stores the data with the word's reserved bits forced to zero, and those bits always read zero. The reserved masks are 0x0000C2F0 for address 0, 0x00F06001 for address 1 and 0x000000F3 for address 2.
- R3: Word addresses 3 to 15 read zero, and writes to them change no stored word and no output.
- R4: core_hold[i] equals bit i of the core reset word (bits 0 to 3 for cores 0 to 3) and changes in the cycle after the write that changes it.
- R5: A write to address 0 that changes core bit i from 1 to 0 raises core_release[i] for exactly one cycle, the cycle after the write, in which core_hold[i] is already low.
- R6: A write that changes core bit i from 0 to 1 raises core_hold[i] and produces no release pulse.
- R7: A write to address 0 that leaves a core bit unchanged produces no pulse for that core, whatever value is written.
- R8: While reset is asserted and in the first cycle after it, core_release is all zero and core_hold is all ones. Entering reset never produces a release pulse.
- R9: Writes to addresses 1 and 2 leave core_hold, core_release and the core reset word unchanged.
- R10: One write may release some cores and hold others at the same time, and each core acts only on its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| core_hold | output | 4 | Per-core hold level |
| core_release | output | 4 | Per-core one-cycle release pulse |

## Verification
The bench targets the edge cases of the transition rule. It rewrites an unchanged value, which would pulse again in a design that acts on levels. It releases some cores while holding others in a single write, which would expose shared or swapped per-core logic. It enters reset with cores running, which a design that treats reset as a write would wrongly turn into release pulses. It also writes all ones to every word and to unmapped addresses, so that a wrong reserved mask, an aliased decode, or the memory word's overlapping reset bits show up as wrong read data.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_SLOTS = 3;

    typedef enum int {
        SLOT_CORE = 0,
        SLOT_TOP  = 1,
        SLOT_MEM  = 2
    } slot_e;

    // Raw reset value of each word before reserved bits are cleared.
    function automatic logic [DATA_W-1:0] slot_reset(int s);
        case (s)
            SLOT_CORE: return 32'h0000_3D0F;
            SLOT_TOP:  return 32'h000F_9FFE;
            SLOT_MEM:  return 32'h0000_000F;
            default:   return '0;
        endcase
    endfunction

    // Reserved (read-zero, write-ignored) bits of each word.
    function automatic logic [DATA_W-1:0] slot_rsvd(int s);
        case (s)
            SLOT_CORE: return 32'h0000_C2F0;
            SLOT_TOP:  return 32'h00F0_6001;
            SLOT_MEM:  return 32'h0000_00F3;
            default:   return '1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] slot_init(int s);
        return slot_reset(s) & ~slot_rsvd(s);
    endfunction

endpackage

// File: rtl/rstctl_reg.sv
module rstctl_reg
    import rstctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] INIT_VAL = '0,
    parameter logic [DATA_W-1:0] RSVD_MSK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    localparam logic [DATA_W-1:0] KEEP_MSK = ~RSVD_MSK;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= INIT_VAL & KEEP_MSK;
        end else if (wr_en) begin
            q <= wdata & KEEP_MSK;
        end
    end

endmodule

// File: rtl/rstctl_core_seq.sv
module rstctl_core_seq #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [NUM_CORES-1:0] old_bits,
    input  logic [NUM_CORES-1:0] new_bits,
    output logic [NUM_CORES-1:0] release_o
);

    // A pulse is registered only on a 1-to-0 change seen at write time.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic falls;
        assign falls = wr_en && old_bits[c] && !new_bits[c];

        always_ff @(posedge clk) begin
            if (rst) begin
                release_o[c] <= 1'b0;
            end else begin
                release_o[c] <= falls;
            end
        end
    end

endmodule

// File: rtl/core_rst_ctrl.sv
module core_rst_ctrl
    import rstctl_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_LSB  = 0,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] core_hold,
    output logic [NUM_CORES-1:0] core_release
);

    localparam int CORE_IDX = int'(SLOT_CORE);

    logic [DATA_W-1:0] slot_q  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_wr;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_wr[g] = bus_wr && (bus_addr == ADDR_W'(g));

        rstctl_reg #(
            .INIT_VAL (slot_reset(g)),
            .RSVD_MSK (slot_rsvd(g))
        ) i_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_en (slot_wr[g]),
            .wdata (bus_wdata),
            .q     (slot_q[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (bus_addr == ADDR_W'(s)) begin
                bus_rdata = slot_q[s];
            end
        end
    end

    logic [NUM_CORES-1:0] old_core_bits;
    logic [NUM_CORES-1:0] new_core_bits;

    assign old_core_bits = slot_q[CORE_IDX][CORE_LSB +: NUM_CORES];
    assign new_core_bits = bus_wdata[CORE_LSB +: NUM_CORES];

    rstctl_core_seq #(
        .NUM_CORES (NUM_CORES)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (slot_wr[CORE_IDX]),
        .old_bits  (old_core_bits),
        .new_bits  (new_core_bits),
        .release_o (core_release)
    );

    assign core_hold = old_core_bits;

endmodule

// File: rtl/core_rst_ctrl_chk.sv
module core_rst_ctrl_chk #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_rdata,
    input logic [NUM_CORES-1:0] core_hold,
    input logic [NUM_CORES-1:0] core_release
);

    // R5
    release_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        |core_release |=> ((core_release & $past(core_release)) == '0));

    // R5
    release_hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (core_release & core_hold) == '0);

    // R5
    release_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        |core_release |-> ($past(bus_wr) && $past(bus_addr) == '0));

    // R4
    hold_stable_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> $stable(core_hold));

    // R8
    no_release_from_reset_chk: assert property (@(posedge clk)
        rst |=> (core_release == '0));

    // R3
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= ADDR_W'(3)) |-> (bus_rdata == '0));

    // R2
    core_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == '0) |-> ((bus_rdata & 32'h0000_C2F0) == '0));

endmodule

bind core_rst_ctrl core_rst_ctrl_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .core_hold    (core_hold),
    .core_release (core_release)
);

// File: tb/test_core_rst_ctrl.sv
module test_core_rst_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] core_hold;
    logic [NC-1:0] core_release;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] mdl [3];
    logic [3:0]  exp_rel = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_rst_ctrl #(.NUM_CORES(NC), .CORE_LSB(0), .ADDR_W(AW)) i_core_rst_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_hold(core_hold), .core_release(core_release)
    );

    function automatic logic [31:0] rsvd_of(int a);
        case (a)
            0: return 32'h0000_C2F0;
            1: return 32'h00F0_6001;
            2: return 32'h0000_00F3;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] init_of(int a);
        case (a)
            0: return 32'h0000_3D0F;
            1: return 32'h000F_9FFE;
            2: return 32'h0000_000C;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [3:0] falls_of(logic [3:0] old_b, logic [3:0] new_b);
        return old_b & ~new_b;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) mdl[i] = init_of(i);
        exp_rel = '0;
    endtask

    task automatic chk_outs(string tag);
        chk({tag, " hold"}, 32'(core_hold), 32'(mdl[0][3:0]));
        chk({tag, " release"}, 32'(core_release), 32'(exp_rel));
    endtask

    // Drives one write; returns at the negedge after the capturing edge.
    task automatic wr(int a, logic [31:0] d);
        exp_rel = (a == 0) ? falls_of(mdl[0][3:0], d[3:0]) : 4'h0;
        if (a < 3) mdl[a] = d & ~rsvd_of(a);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        exp_rel = '0;
        chk_outs(tag);
    endtask

    task automatic rd(int a, string tag);
        bus_addr = AW'(a);
        #1;
        chk(tag, bus_rdata, (a < 3) ? mdl[a] : 32'h0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        chk("R8 hold in reset", 32'(core_hold), 32'hF);
        chk("R8 release in reset", 32'(core_release), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk_outs("R8 after reset");
        for (int a = 0; a < 3; a++) rd(a, "R1 reset value");

        // R3: unmapped addresses
        rd(3, "R3 unmapped read");
        rd(15, "R3 unmapped read");
        wr(5, 32'hFFFF_FFFF);
        chk_outs("R3 unmapped write outputs");
        for (int a = 0; a < 3; a++) rd(a, "R3 words unchanged");

        // R2: reserved bits
        wr(1, 32'hFFFF_FFFF); rd(1, "R2 top mask");
        wr(2, 32'hFFFF_FFFF); rd(2, "R2 mem mask");
        wr(0, 32'hFFFF_FFFF); chk_outs("R7 all ones no change"); rd(0, "R2 core mask");

        // R5: release all cores
        wr(0, 32'h0); chk_outs("R5 release all");
        idle("R5 pulse one cycle");
        // R7: same value rewritten
        wr(0, 32'h0); chk_outs("R7 rewrite zero");
        // R6: hold cores 0 and 2
        wr(0, 32'h5); chk_outs("R6 hold set");
        wr(0, 32'h5); chk_outs("R7 rewrite 5");
        // R10: mixed
        wr(0, 32'hA); chk_outs("R10 mixed release hold");
        idle("R10 after mixed");
        // R9: other words leave cores alone
        wr(1, 32'h0); chk_outs("R9 top write");
        wr(2, 32'h0); chk_outs("R9 mem write");
        rd(0, "R9 core word kept");

        for (int n = 0; n < 400; n++) begin
            int a;
            logic [31:0] d;
            a = (($urandom % 4) == 0) ? int'($urandom % 8) : 0;
            d = $urandom;
            wr(a, d);
            chk_outs("R4 R5 R6 R10 random");
            rd(a, "R2 random readback");
            if (($urandom % 5) == 0) idle("R5 random idle");
        end

        // R8: reset entered while cores are running
        wr(0, 32'h0);
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        repeat (3) @(negedge clk);
        chk("R8 reset release", 32'(core_release), 32'h0);
        chk("R8 reset hold", 32'(core_hold), 32'hF);
        rst = 1'b0;
        @(negedge clk);
        chk_outs("R8 after second reset");
        rd(2, "R1 mem after reset");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule